// File: doc/BRIEF.md
# Heartbeat and Fault Tone Supervisor

This block sends and checks periodic pulse bursts on one line of a daisy chain. It has a transmit side and a receive side. While no fault is pending, the transmitter sends a short heartbeat burst at a slow, fixed period. While a fault is pending, it sends a longer fault-tone burst at a faster period. The receiver counts rising edges within each burst. A burst ends when the line stays quiet for longer than the normal pulse spacing. The receiver then classifies the burst as a heartbeat, a fault tone or noise.

A timing monitor sits after the receiver. It raises a heartbeat-lost level when nothing valid has arrived within the timeout window. It flags a heartbeat that follows the previous heartbeat too closely. A received fault tone restarts the timeout window just as a heartbeat does. All timers advance on a single-cycle tick from a low-frequency oscillator, nominally 262 kHz, so every period parameter is given in ticks. The defaults correspond to pulses about 11.5 µs apart, a 400 ms heartbeat period, a 50 ms fault-tone period, a 200 ms too-fast window and a 1 s timeout.

Top module: `hbft_supervisor`

## Requirements
- R1: While reset is held, tx_line, hb_received, hb_too_fast, hb_lost and ft_detected are all low.
- R2: Each transmitted pulse is high for PULSE_HIGH ticks. Consecutive pulses of a burst rise PULSE_SPACING ticks apart.
- R3: While fault_pending is low, the transmitter sends bursts of HB_PULSES pulses. The first burst starts on the first tick after reset. Later bursts start HB_PERIOD ticks after the previous burst started.
- R4: While fault_pending is high, a burst of FT_PULSES pulses starts once FT_PERIOD ticks have passed since the previous burst started. The kind of a burst is fixed at its start.
- R5: A received burst closes after GAP_TICKS ticks with no rising edge. If it held at least HB_DET and fewer than FT_DET rising edges, hb_received pulses high for one clock. A burst with fewer than HB_DET edges produces no output.
- R6: ft_detected pulses high for one clock when the FT_DET-th rising edge of a burst arrives. That burst never also counts as a heartbeat.
- R7: hb_too_fast pulses together with hb_received when both of the following hold: the previous valid event was a heartbeat, and fewer than HB_FAST ticks have passed since it. A fault tone in between prevents the flag.
- R8: hb_lost rises once HB_TIMEOUT ticks pass with no heartbeat or fault tone since reset or since the last such event. It falls when the next heartbeat or fault tone arrives.
- R9: A quiet gap of GAP_TICKS ticks resets the edge count, so two short bursts separated by such a gap are never combined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe from the low-frequency oscillator |
| fault_pending | input | 1 | Selects fault-tone bursts instead of heartbeats |
| rx_line | input | 1 | Incoming pulse line (asynchronous, synchronised inside) |
| tx_line | output | 1 | Outgoing pulse line |
| hb_received | output | 1 | One-clock strobe for a valid heartbeat |
| hb_too_fast | output | 1 | One-clock strobe for a heartbeat inside the too-fast window |
| hb_lost | output | 1 | Level: timeout expired with no heartbeat or fault tone |
| ft_detected | output | 1 | One-clock strobe for a detected fault tone |

## Verification
The assertions assume the following about the inputs:
- tick is high for a single clock at a time.
- Each rx_line level lasts at least three clocks, so the synchroniser sees every edge.
- The periods exceed the burst lengths, so a new burst can never be due while one is still being sent.

The stimulus meets these conditions. It derives tick from a divide-by-four counter and drives rx_line only on tick boundaries, with pulses one tick high and two ticks low. It changes fault_pending only between bursts, when the period counter is still below the new limit.

// File: rtl/hbft_pkg.sv
package hbft_pkg;

    // Classified outcome of one received burst
    typedef struct packed {
        logic hb;
        logic ft;
    } burst_evt_t;

    // Counter width able to hold the value v
    function automatic int unsigned cw(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/hbft_tx.sv
module hbft_tx
    import hbft_pkg::*;
#(
    parameter int unsigned PULSE_HIGH    = 1,
    parameter int unsigned PULSE_SPACING = 3,
    parameter int unsigned HB_PULSES     = 30,
    parameter int unsigned FT_PULSES     = 90,
    parameter int unsigned HB_PERIOD     = 104800,
    parameter int unsigned FT_PERIOD     = 13100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fault_pending,
    output logic tx_line
);

    localparam int unsigned PER_MAX = (HB_PERIOD > FT_PERIOD) ? HB_PERIOD : FT_PERIOD;
    localparam int unsigned NP_MAX  = (HB_PULSES > FT_PULSES) ? HB_PULSES : FT_PULSES;
    localparam int unsigned PER_W   = cw(PER_MAX);
    localparam int unsigned SLOT_W  = cw(PULSE_SPACING);
    localparam int unsigned IDX_W   = cw(NP_MAX);

    localparam logic [PER_W-1:0]  HB_LIM    = PER_W'(HB_PERIOD - 1);
    localparam logic [PER_W-1:0]  FT_LIM    = PER_W'(FT_PERIOD - 1);
    localparam logic [PER_W-1:0]  PER_SAT   = PER_W'(PER_MAX);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(PULSE_SPACING - 1);
    localparam logic [SLOT_W-1:0] HIGH_L    = SLOT_W'(PULSE_HIGH);
    localparam logic [IDX_W-1:0]  HB_LAST   = IDX_W'(HB_PULSES - 1);
    localparam logic [IDX_W-1:0]  FT_LAST   = IDX_W'(FT_PULSES - 1);

    typedef struct packed {
        logic              first;
        logic              active;
        logic              is_ft;
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  idx;
        logic [PER_W-1:0]  per;
        logic              line;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [PER_W-1:0] lim_d;
    logic [IDX_W-1:0] last_d;

    always_comb begin
        st_d   = st_q;
        lim_d  = fault_pending ? FT_LIM : HB_LIM;
        last_d = st_q.is_ft ? FT_LAST : HB_LAST;
        if (tick) begin
            if (!st_q.active && (st_q.first || st_q.per >= lim_d)) begin
                st_d.first  = 1'b0;
                st_d.active = 1'b1;
                st_d.is_ft  = fault_pending;
                st_d.slot   = '0;
                st_d.idx    = '0;
                st_d.per    = '0;
            end else begin
                if (st_q.per != PER_SAT) begin
                    st_d.per = st_q.per + 1'b1;
                end
                if (st_q.active) begin
                    if (st_q.slot == SLOT_LAST) begin
                        st_d.slot = '0;
                        if (st_q.idx == last_d) begin
                            st_d.active = 1'b0;
                        end else begin
                            st_d.idx = st_q.idx + 1'b1;
                        end
                    end else begin
                        st_d.slot = st_q.slot + 1'b1;
                    end
                end
            end
            st_d.line = st_d.active && (st_d.slot < HIGH_L);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_line = st_q.line;

    // R2: a pulse begins only at the first slot of a pulse position
    assert_pulse_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.line) |-> (st_q.slot == '0));

    // R3: the pulse index never passes the length of the current burst kind
    assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.idx <= (st_q.is_ft ? FT_LAST : HB_LAST)));

    // R4: the kind of a burst stays fixed while it is being sent
    assert_kind_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active)) |-> $stable(st_q.is_ft));

endmodule

// File: rtl/hbft_rx_burst.sv
module hbft_rx_burst
    import hbft_pkg::*;
#(
    parameter int unsigned GAP_TICKS = 8,
    parameter int unsigned HB_DET    = 20,
    parameter int unsigned FT_DET    = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_line,
    output burst_evt_t evt
);

    localparam int unsigned GAP_W = cw(GAP_TICKS);
    localparam int unsigned CNT_W = cw(FT_DET);

    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);
    localparam logic [CNT_W-1:0] HB_L     = CNT_W'(HB_DET);
    localparam logic [CNT_W-1:0] FT_L     = CNT_W'(FT_DET);
    localparam logic [CNT_W-1:0] FT_PRE   = CNT_W'(FT_DET - 1);

    typedef struct packed {
        logic [2:0]       sync;
        logic             open;
        logic [GAP_W-1:0] gap;
        logic [CNT_W-1:0] cnt;
        burst_evt_t       evt;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      rise;

    assign rise = st_q.sync[1] & ~st_q.sync[2];

    always_comb begin
        st_d        = st_q;
        st_d.evt    = '0;
        st_d.sync   = {st_q.sync[1:0], rx_line};
        if (rise) begin
            st_d.open = 1'b1;
            st_d.gap  = '0;
            if (st_q.cnt != FT_L) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt == FT_PRE) begin
                st_d.evt.ft = 1'b1;
            end
        end else if (tick && st_q.open) begin
            if (st_q.gap == GAP_LAST) begin
                st_d.open = 1'b0;
                st_d.gap  = '0;
                st_d.cnt  = '0;
                st_d.evt.hb = (st_q.cnt >= HB_L) && (st_q.cnt < FT_L);
            end else begin
                st_d.gap = st_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt = st_q.evt;

    // R6: a fault tone is reported at most once per burst
    assert_ft_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt.ft |=> !st_q.evt.ft);

    // R5: a heartbeat is reported only as its burst closes
    assert_hb_on_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt.hb |-> (!st_q.open && st_q.cnt == '0));

    // R9: a closed burst leaves no edges counted
    assert_gap_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.open) |-> (st_q.cnt == '0));

endmodule

// File: rtl/hbft_rx_watch.sv
module hbft_rx_watch
    import hbft_pkg::*;
#(
    parameter int unsigned HB_FAST    = 52400,
    parameter int unsigned HB_TIMEOUT = 262000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  burst_evt_t evt,
    output logic       hb_received,
    output logic       hb_too_fast,
    output logic       hb_lost
);

    localparam int unsigned EL_W = cw(HB_TIMEOUT);

    localparam logic [EL_W-1:0] FAST_L = EL_W'(HB_FAST);
    localparam logic [EL_W-1:0] TO_L   = EL_W'(HB_TIMEOUT);
    localparam logic [EL_W-1:0] TO_PRE = EL_W'(HB_TIMEOUT - 1);

    typedef struct packed {
        logic [EL_W-1:0] elapsed;
        logic            prev_hb;
        logic            rcv;
        logic            fast;
        logic            lost;
    } watch_state_t;

    watch_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rcv  = 1'b0;
        st_d.fast = 1'b0;
        if (evt.hb) begin
            st_d.rcv     = 1'b1;
            st_d.fast    = st_q.prev_hb && (st_q.elapsed < FAST_L);
            st_d.elapsed = '0;
            st_d.prev_hb = 1'b1;
            st_d.lost    = 1'b0;
        end else if (evt.ft) begin
            st_d.elapsed = '0;
            st_d.prev_hb = 1'b0;
            st_d.lost    = 1'b0;
        end else if (tick && st_q.elapsed != TO_L) begin
            st_d.elapsed = st_q.elapsed + 1'b1;
            if (st_q.elapsed == TO_PRE) begin
                st_d.lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hb_received = st_q.rcv;
    assign hb_too_fast = st_q.fast;
    assign hb_lost     = st_q.lost;

    // R7: the too-fast flag only accompanies a received heartbeat
    assert_fast_with_hb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fast |-> st_q.rcv);

    // R8: any valid event clears the lost level on the next clock
    assert_lost_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.hb || evt.ft) |=> !st_q.lost);

    // R8: the lost level can only rise on a tick
    assert_lost_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> $past(tick));

endmodule

// File: rtl/hbft_supervisor.sv
module hbft_supervisor
    import hbft_pkg::*;
#(
    parameter int unsigned PULSE_HIGH    = 1,
    parameter int unsigned PULSE_SPACING = 3,
    parameter int unsigned HB_PULSES     = 30,
    parameter int unsigned FT_PULSES     = 90,
    parameter int unsigned HB_PERIOD     = 104800,
    parameter int unsigned FT_PERIOD     = 13100,
    parameter int unsigned GAP_TICKS     = 8,
    parameter int unsigned HB_DET        = 20,
    parameter int unsigned FT_DET        = 60,
    parameter int unsigned HB_FAST       = 52400,
    parameter int unsigned HB_TIMEOUT    = 262000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fault_pending,
    input  logic rx_line,
    output logic tx_line,
    output logic hb_received,
    output logic hb_too_fast,
    output logic hb_lost,
    output logic ft_detected
);

    burst_evt_t rx_evt;

    hbft_tx #(
        .PULSE_HIGH    (PULSE_HIGH),
        .PULSE_SPACING (PULSE_SPACING),
        .HB_PULSES     (HB_PULSES),
        .FT_PULSES     (FT_PULSES),
        .HB_PERIOD     (HB_PERIOD),
        .FT_PERIOD     (FT_PERIOD)
    ) tx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .fault_pending (fault_pending),
        .tx_line       (tx_line)
    );

    hbft_rx_burst #(
        .GAP_TICKS (GAP_TICKS),
        .HB_DET    (HB_DET),
        .FT_DET    (FT_DET)
    ) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_line (rx_line),
        .evt     (rx_evt)
    );

    hbft_rx_watch #(
        .HB_FAST    (HB_FAST),
        .HB_TIMEOUT (HB_TIMEOUT)
    ) watch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .evt         (rx_evt),
        .hb_received (hb_received),
        .hb_too_fast (hb_too_fast),
        .hb_lost     (hb_lost)
    );

    assign ft_detected = rx_evt.ft;

endmodule

// File: tb/hbft_supervisor_tb_top.sv
module hbft_supervisor_tb_top;

    localparam int TPC = 4;   // clocks per tick

    logic clk = 1'b0;
    logic rst_n;
    logic tick;
    logic fault_pending;
    logic rx_line;
    logic tx_line, hb_received, hb_too_fast, hb_lost, ft_detected;

    int checks = 0;
    int fails  = 0;
    int clk_no = 0;

    typedef enum int {EV_HB, EV_FT, EV_FAST, EV_LOST} ev_t;
    typedef struct {
        int    pulses;
        int    interval;
        string tag;
    } tx_exp_t;

    ev_t     exp_rx_q[$];
    tx_exp_t exp_tx_q[$];

    int bursts_seen = 0;
    int hb_cnt      = 0;

    always #2 clk = ~clk;   // 250 MHz

    hbft_supervisor #(
        .PULSE_HIGH(1), .PULSE_SPACING(3), .HB_PULSES(30), .FT_PULSES(90),
        .HB_PERIOD(400), .FT_PERIOD(300), .GAP_TICKS(8), .HB_DET(20),
        .FT_DET(60), .HB_FAST(200), .HB_TIMEOUT(1000)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fault_pending(fault_pending),
        .rx_line(rx_line), .tx_line(tx_line), .hb_received(hb_received),
        .hb_too_fast(hb_too_fast), .hb_lost(hb_lost), .ft_detected(ft_detected)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input ev_t e);
        case (e)
            EV_HB:   return "R5";
            EV_FT:   return "R6";
            EV_FAST: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic take_rx(input ev_t got);
        ev_t e;
        if (exp_rx_q.size() == 0) begin
            check(1'b0, tag_of(got), "unexpected event", int'(got), -1);
        end else begin
            e = exp_rx_q.pop_front();
            check(e == got, tag_of(e), "event kind", int'(got), int'(e));
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (tick !== 1'b1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) wait_tick();
    endtask

    task automatic send_burst(input int n);
        for (int i = 0; i < n; i++) begin
            rx_line = 1'b1;
            wait_tick();
            rx_line = 1'b0;
            wait_tick();
            wait_tick();
        end
    endtask

    // tick generator: one clock in four
    initial begin
        int div;
        div  = 0;
        tick = 1'b0;
        forever begin
            @(negedge clk);
            div  = (div + 1) % TPC;
            tick = (div == 0);
        end
    end

    always @(posedge clk) clk_no <= clk_no + 1;

    // receive-side monitor
    logic lost_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (ft_detected) take_rx(EV_FT);
            if (hb_received) begin
                hb_cnt++;
                take_rx(EV_HB);
            end
            if (hb_too_fast) take_rx(EV_FAST);
            if (hb_lost && !lost_prev) take_rx(EV_LOST);
            lost_prev = hb_lost;
        end
    end

    // transmit-side monitor
    logic tx_prev = 1'b0;
    bit   in_burst = 1'b0;
    int   pulses = 0, hi_len = 0, lo_len = 0, last_rise = 0;
    int   cur_start = 0, prev_start = 0;
    always @(negedge clk) begin
        tx_exp_t e;
        if (rst_n === 1'b1) begin
            if (tx_line) begin
                if (!tx_prev) begin
                    if (!in_burst) begin
                        in_burst  = 1'b1;
                        pulses    = 0;
                        cur_start = clk_no;
                    end else begin
                        check(clk_no - last_rise == 3 * TPC, "R2", "pulse spacing clocks",
                              clk_no - last_rise, 3 * TPC);
                    end
                    pulses++;
                    last_rise = clk_no;
                    hi_len = 0;
                end
                hi_len++;
                lo_len = 0;
            end else begin
                if (tx_prev) begin
                    check(hi_len == TPC, "R2", "pulse high clocks", hi_len, TPC);
                end
                if (in_burst) begin
                    lo_len++;
                    if (lo_len > 6 * TPC) begin
                        in_burst = 1'b0;
                        bursts_seen++;
                        if (exp_tx_q.size() != 0) begin
                            e = exp_tx_q.pop_front();
                            check(pulses == e.pulses, e.tag, "burst pulses", pulses, e.pulses);
                            if (e.interval >= 0) begin
                                check((cur_start - prev_start) == e.interval * TPC, e.tag,
                                      "burst start interval ticks",
                                      (cur_start - prev_start) / TPC, e.interval);
                            end
                        end
                        prev_start = cur_start;
                    end
                end
            end
            tx_prev = tx_line;
        end
    end

    task automatic tx_driver();
        exp_tx_q.push_back('{30, -1, "R3"});
        exp_tx_q.push_back('{30, 400, "R3"});
        exp_tx_q.push_back('{90, 300, "R4"});
        exp_tx_q.push_back('{90, 300, "R4"});
        exp_tx_q.push_back('{30, 400, "R3"});
        exp_tx_q.push_back('{30, 400, "R3"});
        wait (bursts_seen == 2);
        idle(20);
        fault_pending = 1'b1;
        wait (bursts_seen == 4);
        @(negedge clk);
        fault_pending = 1'b0;
        wait (bursts_seen == 6);
    endtask

    task automatic rx_driver();
        int n0;
        idle(5);
        // R5: full heartbeat, no previous one so no too-fast flag
        exp_rx_q.push_back(EV_HB);
        send_burst(30);
        idle(250);
        // R5: 25 edges still a heartbeat; far enough apart for R7
        exp_rx_q.push_back(EV_HB);
        send_burst(25);
        idle(50);
        // R7: exactly HB_DET edges, arriving too soon after the last heartbeat
        exp_rx_q.push_back(EV_HB);
        exp_rx_q.push_back(EV_FAST);
        send_burst(20);
        idle(300);
        // R5: one edge short of a heartbeat is ignored
        n0 = hb_cnt;
        send_burst(19);
        idle(12);
        check(hb_cnt == n0, "R5", "heartbeats after short burst", hb_cnt, n0);
        // R9: two halves split by a long gap do not combine
        n0 = hb_cnt;
        send_burst(15);
        idle(10);
        send_burst(15);
        idle(12);
        check(hb_cnt == n0, "R9", "heartbeats after split burst", hb_cnt, n0);
        idle(400);
        check(hb_lost == 1'b0, "R8", "hb_lost before timeout", int'(hb_lost), 0);
        // R8: timeout expires
        exp_rx_q.push_back(EV_LOST);
        idle(300);
        check(hb_lost == 1'b1, "R8", "hb_lost after timeout", int'(hb_lost), 1);
        // R6: fault tone detected, clears lost
        exp_rx_q.push_back(EV_FT);
        send_burst(60);
        idle(2);
        check(hb_lost == 1'b0, "R8", "hb_lost after fault tone", int'(hb_lost), 0);
        idle(10);
        // R7: quick heartbeat after a fault tone gets no too-fast flag
        exp_rx_q.push_back(EV_HB);
        send_burst(20);
        idle(100);
        // R7: quick heartbeat after a heartbeat is flagged
        exp_rx_q.push_back(EV_HB);
        exp_rx_q.push_back(EV_FAST);
        send_burst(20);
        idle(20);
        // R6: a long fault tone is reported once and never as a heartbeat
        exp_rx_q.push_back(EV_FT);
        send_burst(90);
        idle(20);
    endtask

    initial begin
        rst_n         = 1'b0;
        fault_pending = 1'b0;
        rx_line       = 1'b0;
        repeat (10) @(negedge clk);
        check(tx_line == 1'b0, "R1", "tx_line in reset", int'(tx_line), 0);
        check(hb_received == 1'b0 && hb_too_fast == 1'b0, "R1", "strobes in reset",
              int'(hb_received) + int'(hb_too_fast), 0);
        check(hb_lost == 1'b0 && ft_detected == 1'b0, "R1", "flags in reset",
              int'(hb_lost) + int'(ft_detected), 0);
        rst_n = 1'b1;
        fork
            tx_driver();
            rx_driver();
        join
        idle(40);
        check(exp_rx_q.size() == 0, "R5", "receive events outstanding", exp_rx_q.size(), 0);
        check(exp_tx_q.size() == 0, "R3", "transmit bursts outstanding", exp_tx_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule